// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block gathers the four interrupt causes of one serial channel (receive, error, transmit, modem) into a single interrupt request. Each cause latches into a source register. A mask register hides chosen causes. A pending register holds the unmasked causes, and the interrupt line is the OR of the pending bits.

The transmit and receive causes come from level comparisons. The FIFO occupancy counts are compared against trigger levels, which are built from small programmable fields scaled by a multiplier. The multiplier is fixed by the channel number when the block is built. Error, modem, transmit-done and receive-timeout causes arrive as single-cycle strobes from the surrounding UART.

Software clears and masks causes through a small write port. The block also drives a receive-DMA busy flag, which tells a DMA engine that a DMA-mode receiver has nothing to read. The FIFOs and all serial timing sit outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. A strobe on `rx_tout_i`, `err_evt_i`, `tx_done_i` or `modem_evt_i` sets the matching source bit at the next clock edge. Source bits stay set until software clears them.
- R2: On every update cycle, pending is loaded with (next source AND NOT next mask). `irq_o` is the OR of the pending bits. A pending bit is never set while its mask bit is set.
- R3: A write with select 2'b00 (pending) clears the written bits in source and pending, and counts as an update.
- R4: A write with select 2'b01 (source) clears only the written source bits. Pending and `irq_o` hold their old value until the next update. An update is any active set condition, a pending write or a mask write.
- R5: When a source bit is set and cleared in the same cycle, the set wins.
- R6: Trigger multiplier by channel: 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R7: With the FIFO enabled, the transmit source is set while `tx_cnt_i` is less than or equal to `tx_trig_i` times the multiplier.
- R8: With the FIFO enabled, the receive source is set under either of two conditions: `rx_cnt_i` is at least (`rx_trig_i` + 1) times the multiplier, or `rx_cnt_i` is nonzero while `rx_tout_en_i` is low.
- R9: With the FIFO disabled, the receive source follows `rx_ready_i`, and the count comparisons set nothing.
- R10: `dma_busy_o` is high in the same cycle, with no clock delay, exactly when `rx_mode_i` is 2'b10 and `rx_cnt_i` is zero.
- R11: A write with select 2'b10 loads the mask from `wr_data_i`. A write with select 2'b11 changes nothing.
- R12: After reset, source, mask and pending are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 pending, 01 source, 10 mask, 11 none |
| wr_data_i | input | 4 | Write data, one bit per source |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_trig_i | input | 3 | Transmit trigger field |
| rx_trig_i | input | 3 | Receive trigger field (used plus one) |
| rx_tout_en_i | input | 1 | Receive timeout enable |
| rx_mode_i | input | 2 | Receive mode, 2'b10 selects DMA |
| tx_cnt_i | input | CNT_W | Transmit FIFO occupancy |
| rx_cnt_i | input | CNT_W | Receive FIFO occupancy |
| rx_ready_i | input | 1 | Receive data ready, used with the FIFO disabled |
| rx_tout_i | input | 1 | Receive timeout strobe |
| tx_done_i | input | 1 | Transmit write done strobe |
| err_evt_i | input | 1 | Error event strobe |
| modem_evt_i | input | 1 | Modem event strobe |
| src_o | output | 4 | Source register |
| mask_o | output | 4 | Mask register |
| pend_o | output | 4 | Pending register |
| irq_o | output | 1 | Interrupt request |
| dma_busy_o | output | 1 | Receive DMA busy |

## Verification
Source, mask, pending and the interrupt line all change at the first rising edge after the inputs that cause the change, so they are due one cycle after a stimulus. The DMA busy flag is combinational and is due in the same cycle. The bench drives inputs on the falling edge and checks the busy flag 1 ns later. It checks the registered outputs on the following falling edge against a model that advances one step per cycle. Directed cases target the stale pending value after a source-only clear, set winning over clear, and both trigger boundaries.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned NSRC      = 4;
  localparam int unsigned SRC_RX    = 0;
  localparam int unsigned SRC_ERR   = 1;
  localparam int unsigned SRC_TX    = 2;
  localparam int unsigned SRC_MODEM = 3;

  localparam int unsigned TRIG_W    = 3;
  localparam logic [1:0]  RX_MODE_DMA = 2'b10;

  typedef enum logic [1:0] {
    SEL_PEND = 2'b00,
    SEL_SRC  = 2'b01,
    SEL_MASK = 2'b10,
    SEL_NONE = 2'b11
  } wr_sel_e;

  function automatic int unsigned chan_mult(int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              rx_tout_en_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              rx_ready_i,
  output logic              tx_set_o,
  output logic              rx_set_o
);

  localparam int unsigned MULT  = chan_mult(CHANNEL);
  localparam int unsigned SHIFT = (MULT > 1) ? $clog2(MULT) : 0;
  localparam int unsigned LVL_W = TRIG_W + 1 + 6;
  localparam int unsigned CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [TRIG_W:0]  rx_fld_p1;
  logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x, tx_lvl_x, rx_lvl_x;
  logic             tx_hit, rx_hit, rx_nz;

  assign rx_fld_p1 = {1'b0, rx_trig_i} + 1'b1;

  // every nonzero multiplier is a power of two: scale by shift
  generate
    if (MULT == 0) begin : g_no_lvl
      assign tx_lvl = '0;
      assign rx_lvl = '0;
    end else begin : g_shift_lvl
      assign tx_lvl = LVL_W'(tx_trig_i) << SHIFT;
      assign rx_lvl = LVL_W'(rx_fld_p1) << SHIFT;
    end
  endgenerate

  assign tx_cnt_x = CMP_W'(tx_cnt_i);
  assign rx_cnt_x = CMP_W'(rx_cnt_i);
  assign tx_lvl_x = CMP_W'(tx_lvl);
  assign rx_lvl_x = CMP_W'(rx_lvl);

  assign tx_hit = tx_cnt_x <= tx_lvl_x;
  assign rx_hit = rx_cnt_x >= rx_lvl_x;
  assign rx_nz  = (|rx_cnt_i) & ~rx_tout_en_i;

  assign tx_set_o = fifo_en_i & tx_hit;
  assign rx_set_o = fifo_en_i ? (rx_hit | rx_nz) : rx_ready_i;

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_en_i,
  input  wr_sel_e      wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] src_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);

  logic [N-1:0] src_q, src_d, mask_q, mask_d, pend_q, pend_d, clr;
  logic         mask_we, upd;

  always_comb begin
    clr     = '0;
    mask_we = 1'b0;
    upd     = |set_i;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_PEND: begin clr = wr_data_i; upd = 1'b1; end
        SEL_SRC:  clr = wr_data_i;
        SEL_MASK: begin mask_we = 1'b1; upd = 1'b1; end
        default:  ;
      endcase
    end
  end

  // set beats clear per bit
  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      assign src_d[g] = (src_q[g] & ~clr[g]) | set_i[g];
    end
  endgenerate

  assign mask_d = mask_we ? wr_data_i : mask_q;
  // source-only clears leave pending stale until the next update
  assign pend_d = upd ? (src_d & ~mask_d) : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign src_o  = src_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [3:0]       wr_data_i,
  input  logic             fifo_en_i,
  input  logic [2:0]       tx_trig_i,
  input  logic [2:0]       rx_trig_i,
  input  logic             rx_tout_en_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             rx_ready_i,
  input  logic             rx_tout_i,
  input  logic             tx_done_i,
  input  logic             err_evt_i,
  input  logic             modem_evt_i,
  output logic [3:0]       src_o,
  output logic [3:0]       mask_o,
  output logic [3:0]       pend_o,
  output logic             irq_o,
  output logic             dma_busy_o
);

  logic            tx_lvl_set, rx_lvl_set;
  logic [NSRC-1:0] set_vec;

  uart_irq_trig #(
    .CHANNEL (CHANNEL),
    .CNT_W   (CNT_W)
  ) i_trig (
    .fifo_en_i    (fifo_en_i),
    .tx_trig_i    (tx_trig_i),
    .rx_trig_i    (rx_trig_i),
    .rx_tout_en_i (rx_tout_en_i),
    .tx_cnt_i     (tx_cnt_i),
    .rx_cnt_i     (rx_cnt_i),
    .rx_ready_i   (rx_ready_i),
    .tx_set_o     (tx_lvl_set),
    .rx_set_o     (rx_lvl_set)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RX]    = rx_lvl_set | rx_tout_i;
    set_vec[SRC_ERR]   = err_evt_i;
    set_vec[SRC_TX]    = tx_lvl_set | tx_done_i;
    set_vec[SRC_MODEM] = modem_evt_i;
  end

  uart_irq_regs #(
    .N (NSRC)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .src_o     (src_o),
    .mask_o    (mask_o),
    .pend_o    (pend_o),
    .irq_o     (irq_o)
  );

  assign dma_busy_o = (rx_mode_i == RX_MODE_DMA) && (rx_cnt_i == '0);

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [3:0]       wr_data_i,
  input logic             fifo_en_i,
  input logic [1:0]       rx_mode_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic             rx_ready_i,
  input logic             rx_tout_i,
  input logic             tx_done_i,
  input logic             err_evt_i,
  input logic             modem_evt_i,
  input logic [3:0]       src_o,
  input logic [3:0]       mask_o,
  input logic [3:0]       pend_o,
  input logic             irq_o,
  input logic             dma_busy_o
);

  logic quiet;
  assign quiet = !fifo_en_i && !rx_ready_i && !rx_tout_i && !tx_done_i
                 && !err_evt_i && !modem_evt_i;

  assert_err_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> src_o[1]);

  assert_modem_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modem_evt_i |=> src_o[3]);

  assert_irq_or_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|pend_o));

  assert_pend_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & mask_o) == 4'b0);

  assert_pend_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'b00 && quiet)
      |=> ((src_o | pend_o) & $past(wr_data_i)) == 4'b0);

  assert_src_wr_stale_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'b01 && quiet) |=> pend_o == $past(pend_o));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i[1] && tx_done_i) |=> src_o[2]);

  assert_dma_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mode_i == 2'b10 && rx_cnt_i == '0) |-> dma_busy_o);

  assert_mask_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'b10) |=> mask_o == $past(wr_data_i));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .fifo_en_i   (fifo_en_i),
  .rx_mode_i   (rx_mode_i),
  .rx_cnt_i    (rx_cnt_i),
  .rx_ready_i  (rx_ready_i),
  .rx_tout_i   (rx_tout_i),
  .tx_done_i   (tx_done_i),
  .err_evt_i   (err_evt_i),
  .modem_evt_i (modem_evt_i),
  .src_o       (src_o),
  .mask_o      (mask_o),
  .pend_o      (pend_o),
  .irq_o       (irq_o),
  .dma_busy_o  (dma_busy_o)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

  localparam int unsigned CH = 1;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 0;
  logic [1:0]    wr_sel = 0;
  logic [3:0]    wr_data = 0;
  logic          fifo_en = 0;
  logic [2:0]    tx_trig = 0, rx_trig = 0;
  logic          tout_en = 0;
  logic [1:0]    rx_mode = 0;
  logic [CW-1:0] tx_cnt = 0, rx_cnt = 0;
  logic          rx_ready = 0, rx_tout = 0, tx_done = 0, err_evt = 0, modem_evt = 0;
  logic [3:0]    src, mask, pend;
  logic          irq, dma_busy;

  logic [3:0] m_src = 0, m_mask = 0, m_pend = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(CH), .CNT_W(CW)) i_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .fifo_en_i(fifo_en), .tx_trig_i(tx_trig),
    .rx_trig_i(rx_trig), .rx_tout_en_i(tout_en), .rx_mode_i(rx_mode),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .rx_ready_i(rx_ready),
    .rx_tout_i(rx_tout), .tx_done_i(tx_done), .err_evt_i(err_evt),
    .modem_evt_i(modem_evt), .src_o(src), .mask_o(mask), .pend_o(pend),
    .irq_o(irq), .dma_busy_o(dma_busy)
  );

  // R6 multiplier table
  function automatic int mult_of(int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  function automatic logic [3:0] exp_set();
    logic [3:0] s;
    int txl, rxl;
    txl = int'(tx_trig) * mult_of(CH);
    rxl = (int'(rx_trig) + 1) * mult_of(CH);
    s[0] = rx_tout | (fifo_en ? ((rx_cnt != 0 && !tout_en) || int'(rx_cnt) >= rxl)
                              : rx_ready);
    s[1] = err_evt;
    s[2] = tx_done | (fifo_en && int'(tx_cnt) <= txl);
    s[3] = modem_evt;
    return s;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // inputs are already driven; advance model and device one edge
  task automatic cycle(string tag);
    logic [3:0] s, clr, ns, nm;
    logic upd;
    #1;
    chk({tag, " R10 dma_busy"}, {3'b0, dma_busy},
        {3'b0, (rx_mode == 2'b10 && rx_cnt == 0)});
    s   = exp_set();
    clr = (wr_en && !wr_sel[1]) ? wr_data : 4'b0;
    upd = (|s) || (wr_en && (wr_sel == 2'b00 || wr_sel == 2'b10));
    ns  = (m_src & ~clr) | s;
    nm  = (wr_en && wr_sel == 2'b10) ? wr_data : m_mask;
    if (upd) m_pend = ns & ~nm;
    m_src = ns;
    m_mask = nm;
    @(negedge clk);
    chk({tag, " src"},  src,  m_src);
    chk({tag, " mask"}, mask, m_mask);
    chk({tag, " pend"}, pend, m_pend);
    chk({tag, " irq"},  {3'b0, irq}, {3'b0, |m_pend});
  endtask

  task automatic idle();
    wr_en = 0; rx_tout = 0; tx_done = 0; err_evt = 0; modem_evt = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12 reset src",  src,  4'h0);
    chk("R12 reset mask", mask, 4'h0);
    chk("R12 reset pend", pend, 4'h0);
    chk("R12 reset irq",  {3'b0, irq}, 4'h0);
    @(negedge clk);

    // R1 R4 stale pending after source-only clear
    err_evt = 1; cycle("R1 error strobe"); idle();
    cycle("R1 hold");
    wr(2'b01, 4'b0010); cycle("R4 source clear"); idle();
    chk("R4 irq held", {3'b0, irq}, 4'h1);
    wr(2'b00, 4'b0010); cycle("R3 pending clear"); idle();
    chk("R3 irq low", {3'b0, irq}, 4'h0);

    // R9 fifo disabled follows ready; counts ignored
    tx_cnt = 0; rx_cnt = 200; rx_ready = 0; cycle("R9 no ready");
    rx_ready = 1; cycle("R9 ready"); rx_ready = 0;
    wr(2'b00, 4'hf); cycle("R9 clear"); idle();

    // R7 tx boundary, multiplier 8, field 1
    fifo_en = 1; tx_trig = 1; rx_trig = 0; tout_en = 1; rx_cnt = 7;
    tx_cnt = 9; wr(2'b00, 4'hf); cycle("R7 above level"); idle();
    tx_cnt = 8; cycle("R6 R7 at level");
    // R5 set wins over clear
    wr(2'b00, 4'b0100); cycle("R5 set beats clear"); idle();
    chk("R5 tx kept", src & 4'b0100, 4'b0100);

    // R8 rx boundary: level (0+1)*8
    tx_cnt = 200; rx_cnt = 7; wr(2'b00, 4'hf); cycle("R8 below level"); idle();
    rx_cnt = 8; cycle("R8 at level");
    tout_en = 0; rx_cnt = 1; wr(2'b00, 4'hf); cycle("R8 nonzero no timeout"); idle();

    // R11 mask load and ignored select
    wr(2'b10, 4'b0101); cycle("R11 mask"); idle();
    wr(2'b11, 4'b1111); cycle("R11 select 11 ignored"); idle();
    modem_evt = 1; rx_tout = 1; cycle("R1 R2 modem masked view"); idle();

    // R10 dma busy
    rx_mode = 2'b10; rx_cnt = 0; cycle("R10 busy");
    rx_cnt = 1; cycle("R10 data present");
    rx_mode = 2'b01; rx_cnt = 0; cycle("R10 other mode");

    // random mix
    for (int i = 0; i < 600; i++) begin
      fifo_en   = ($urandom % 4) != 0;
      tx_trig   = 3'($urandom);
      rx_trig   = 3'($urandom);
      tout_en   = 1'($urandom);
      rx_mode   = 2'($urandom);
      tx_cnt    = CW'($urandom % 80);
      rx_cnt    = CW'($urandom % 80);
      rx_ready  = ($urandom % 4) == 0;
      rx_tout   = ($urandom % 8) == 0;
      tx_done   = ($urandom % 8) == 0;
      err_evt   = ($urandom % 8) == 0;
      modem_evt = ($urandom % 8) == 0;
      wr_en     = ($urandom % 3) == 0;
      wr_sel    = 2'($urandom);
      wr_data   = 4'($urandom);
      cycle("R1 R2 R3 R4 R7 R8 random");
    end
    idle();
    summary();
  end

endmodule